// File: doc/BRIEF.md
# Triggered Multi-Mode Sample FIFO

This block buffers up to 32 three-axis sample sets. Each set is an X, Y and Z word of 16 bits. A data source offers a new set with a one-cycle valid strobe, and a host drains sets one at a time with a pop strobe. A 3-bit mode input picks the fill policy:

- pass-through, where only the newest set is shown;
- fill until full, then stop;
- fill with overwrite of the oldest set;
- overwrite until a trigger edge, then fill until full and stop;
- pass-through until a trigger edge, then fill with overwrite.

The trigger input must already be synchronised to the clock. The block reports the number of unread sets and a threshold flag against a programmable level. It also reports a sticky flag that records that an unread set was lost. An enable input freezes the whole block when it is low. The interrupt routing and the register access that would surround the block live elsewhere.

Top module: `tsf_top`

## Requirements
- R1: After reset the unread count is 0, the threshold flag and the overrun flag are 0, and the three output words are 0.
- R2: Pass-through mode (mode 000) stores nothing and holds the unread count at 0. Each offered set appears on the output words one cycle later, and pops have no effect. Any cycle spent enabled in this mode empties the FIFO and clears the overrun flag.
- R3: Stop mode (mode 001) stores sets in arrival order. A pop puts the oldest unread set on the output words one cycle later. Once 32 sets are held, storing halts, and it stays halted after pops until pass-through mode and then mode 001 are selected again.
- R4: Overwrite mode (mode 110): when the FIFO is full and a set arrives without a pop, the oldest set is discarded, the count stays at 32 and the overrun flag is set.
- R5: The unread count is 6 bits wide and runs from 0 (empty) to 32 (full). It never exceeds 32.
- R6: The threshold flag is 1 exactly when the 5-bit threshold level is non-zero and the unread count is greater than or equal to that level.
- R7: Once set, the overrun flag stays 1 until pass-through mode is applied or reset is asserted.
- R8: Mode 011 follows the overwrite policy until a rising edge on the trigger input. From the cycle after that edge it follows the stop policy.
- R9: Mode 100 follows the pass-through policy until a rising edge on the trigger input. A set offered in the edge cycle is only shown on the outputs. Sets from the next cycle on are stored with the overwrite policy.
- R10: With enable at 0, offered sets, pops and trigger handling have no effect: count, flags and output words hold.
- R11: A pop on an empty FIFO leaves the output words and the count unchanged. In the overwrite policy, a push and a pop in the same cycle leave the count unchanged.
- R12: Reserved modes (010, 101, 111) ignore offered sets but still allow pops. Any change of the mode input forgets a trigger seen earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Block enable |
| mode_sel | input | 3 | Fill policy select |
| thr_level | input | 5 | Threshold level, 0 disables the flag |
| trig_in | input | 1 | Synchronised trigger, rising edge active |
| smp_valid | input | 1 | New sample set offered this cycle |
| smp_x | input | 16 | X word of offered set |
| smp_y | input | 16 | Y word of offered set |
| smp_z | input | 16 | Z word of offered set |
| rd_pop | input | 1 | Host pop request |
| out_x | output | 16 | X word of presented set |
| out_y | output | 16 | Y word of presented set |
| out_z | output | 16 | Z word of presented set |
| unread_cnt | output | 6 | Number of unread sets |
| thr_hit | output | 1 | Count at or above threshold level |
| ovr_sticky | output | 1 | A set was lost by overwrite |

## Verification
If a read pointer drifts, the popped words stop matching the expected arrival order on the very next pop. If the fill counter or the halt latch goes wrong, the unread count departs from the bench's running total in the same cycle. A lost or premature trigger arm is visible once the FIFO reaches full: within one push, the overrun flag and the count show whether the overwrite policy or the stop policy was in force. The threshold flag is compared against every level at every fill depth, so any slip in the comparison shows at once.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam logic [2:0] MODE_PASS      = 3'b000;
    localparam logic [2:0] MODE_STOP      = 3'b001;
    localparam logic [2:0] MODE_OVW_STOP  = 3'b011;
    localparam logic [2:0] MODE_PASS_OVW  = 3'b100;
    localparam logic [2:0] MODE_OVW       = 3'b110;

    typedef enum logic [1:0] {
        POL_PASS = 2'd0,
        POL_STOP = 2'd1,
        POL_OVW  = 2'd2,
        POL_HOLD = 2'd3
    } policy_e;

    function automatic policy_e policy_of(input logic [2:0] mode, input logic armed);
        policy_e p;
        case (mode)
            MODE_PASS:     p = POL_PASS;
            MODE_STOP:     p = POL_STOP;
            MODE_OVW:      p = POL_OVW;
            MODE_OVW_STOP: p = armed ? POL_STOP : POL_OVW;
            MODE_PASS_OVW: p = armed ? POL_OVW : POL_PASS;
            default:       p = POL_HOLD;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 48,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/tsf_trig.sv
module tsf_trig (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic [2:0] mode_sel,
    input  logic       trig_in,
    output logic       armed
);

    typedef struct packed {
        logic [2:0] mode;
        logic       prev;
        logic       armed;
    } trig_t;

    trig_t tq_q, tq_d;
    logic  mode_same;

    assign mode_same = (mode_sel == tq_q.mode);

    always_comb begin
        tq_d      = tq_q;
        tq_d.mode = mode_sel;
        if (fifo_en) begin
            tq_d.prev = trig_in;
            if (!mode_same) begin
                tq_d.armed = 1'b0;
            end else if (trig_in && !tq_q.prev) begin
                tq_d.armed = 1'b1;
            end
        end else if (!mode_same) begin
            tq_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tq_q <= '0;
        end else begin
            tq_q <= tq_d;
        end
    end

    assign armed = tq_q.armed && mode_same;

    p_arm_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tq_q.armed && !(fifo_en && trig_in && !tq_q.prev)) |=> !tq_q.armed);

endmodule

// File: rtl/tsf_flags.sv
module tsf_flags #(
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic [AW-1:0]    level,
    output logic             thr_hit
);

    always_comb begin
        thr_hit = (level != '0) && (count >= {1'b0, level});
    end

endmodule

// File: rtl/tsf_top.sv
module tsf_top #(
    parameter int DEPTH  = 32,
    parameter int WORD_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1,
    localparam int SET_W = 3 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [2:0]        mode_sel,
    input  logic [AW-1:0]     thr_level,
    input  logic              trig_in,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_x,
    input  logic [WORD_W-1:0] smp_y,
    input  logic [WORD_W-1:0] smp_z,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] out_x,
    output logic [WORD_W-1:0] out_y,
    output logic [WORD_W-1:0] out_z,
    output logic [CNT_W-1:0]  unread_cnt,
    output logic              thr_hit,
    output logic              ovr_sticky
);
    import tsf_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]    wr;
        logic [AW-1:0]    rd;
        logic [CNT_W-1:0] count;
        logic             ovr;
        logic             halted;
        logic [SET_W-1:0] shown;
    } ctl_t;

    ctl_t             cq_q, cq_d;
    logic             armed;
    policy_e          pol;
    logic             push_acc, pop_ok, overwrite;
    logic [SET_W-1:0] smp_set, rd_data;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign smp_set = {smp_x, smp_y, smp_z};
    assign pol     = policy_of(mode_sel, armed);

    tsf_trig trig_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .mode_sel(mode_sel),
        .trig_in (trig_in),
        .armed   (armed)
    );

    tsf_store #(.DEPTH(DEPTH), .DATA_W(SET_W)) store_i (
        .clk    (clk),
        .wr_en  (push_acc),
        .wr_addr(cq_q.wr),
        .wr_data(smp_set),
        .rd_addr(cq_q.rd),
        .rd_data(rd_data)
    );

    tsf_flags #(.DEPTH(DEPTH)) flags_i (
        .count  (cq_q.count),
        .level  (thr_level),
        .thr_hit(thr_hit)
    );

    always_comb begin
        cq_d      = cq_q;
        push_acc  = 1'b0;
        pop_ok    = 1'b0;
        overwrite = 1'b0;
        if (fifo_en) begin
            if (pol == POL_PASS) begin
                cq_d.wr     = '0;
                cq_d.rd     = '0;
                cq_d.count  = '0;
                cq_d.ovr    = 1'b0;
                cq_d.halted = 1'b0;
                if (smp_valid) begin
                    cq_d.shown = smp_set;
                end
            end else begin
                pop_ok = rd_pop && (cq_q.count != '0);
                if (pol == POL_OVW) begin
                    push_acc = smp_valid;
                end else if (pol == POL_STOP) begin
                    push_acc = smp_valid && !cq_q.halted && (cq_q.count < FULL_CNT);
                end
                overwrite = push_acc && (cq_q.count == FULL_CNT) && !pop_ok;
                if (pop_ok) begin
                    cq_d.shown = rd_data;
                    cq_d.rd    = ptr_inc(cq_q.rd);
                end
                if (push_acc) begin
                    cq_d.wr = ptr_inc(cq_q.wr);
                end
                if (overwrite) begin
                    cq_d.rd  = ptr_inc(cq_q.rd);
                    cq_d.ovr = 1'b1;
                end else begin
                    cq_d.count = cq_q.count + CNT_W'(push_acc) - CNT_W'(pop_ok);
                end
                if ((pol == POL_STOP) && (cq_d.count == FULL_CNT)) begin
                    cq_d.halted = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq_q <= '0;
        end else begin
            cq_q <= cq_d;
        end
    end

    assign out_x      = cq_q.shown[3*WORD_W-1:2*WORD_W];
    assign out_y      = cq_q.shown[2*WORD_W-1:WORD_W];
    assign out_z      = cq_q.shown[WORD_W-1:0];
    assign unread_cnt = cq_q.count;
    assign ovr_sticky = cq_q.ovr;

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unread_cnt <= FULL_CNT);

    p_pass_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && pol == POL_PASS) |=> (unread_cnt == '0 && !ovr_sticky));

    p_halt_no_growth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && cq_q.halted) |=> (unread_cnt <= $past(unread_cnt)));

    p_overrun_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && pol == POL_OVW && smp_valid && !rd_pop && unread_cnt == FULL_CNT)
        |=> (ovr_sticky && unread_cnt == FULL_CNT));

    p_ovr_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_sticky && !(fifo_en && pol == POL_PASS)) |=> ovr_sticky);

    p_disabled_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> ($stable(unread_cnt) && $stable(ovr_sticky) && $stable(out_x)
                      && $stable(out_y) && $stable(out_z)));

    p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && pol != POL_PASS && rd_pop && !smp_valid && unread_cnt == '0)
        |=> ($stable(out_x) && $stable(out_y) && $stable(out_z) && unread_cnt == '0));

    p_hold_no_push_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && pol == POL_HOLD) |=> (unread_cnt <= $past(unread_cnt)));

endmodule

// File: tb/tsf_top_tb_top.sv
module tsf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b1;
    logic [2:0]  mode_sel = 3'b000;
    logic [4:0]  thr_level = 5'd0;
    logic        trig_in = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic        rd_pop = 1'b0;
    logic [15:0] out_x, out_y, out_z;
    logic [5:0]  unread_cnt;
    logic        thr_hit, ovr_sticky;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tsf_top dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_sel(mode_sel),
        .thr_level(thr_level), .trig_in(trig_in), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .rd_pop(rd_pop),
        .out_x(out_x), .out_y(out_y), .out_z(out_z), .unread_cnt(unread_cnt),
        .thr_hit(thr_hit), .ovr_sticky(ovr_sticky)
    );

    function automatic logic [15:0] vx(input int id); return 16'(id * 7 + 3); endfunction
    function automatic logic [15:0] vy(input int id); return 16'(16'h4000 ^ id); endfunction
    function automatic logic [15:0] vz(input int id); return 16'(~id); endfunction

    task automatic chk_cnt(input int exp, input string tag);
        checks++;
        if (unread_cnt != 6'(exp)) begin
            failures++;
            $display("FAIL %s count actual=%0d expected=%0d", tag, unread_cnt, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s flag actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_out(input int id, input string tag);
        checks++;
        if (out_x != vx(id) || out_y != vy(id) || out_z != vz(id)) begin
            failures++;
            $display("FAIL %s data actual=%h_%h_%h expected=%h_%h_%h", tag,
                     out_x, out_y, out_z, vx(id), vy(id), vz(id));
        end
    endtask

    task automatic push(input int id);
        smp_valid = 1'b1; smp_x = vx(id); smp_y = vy(id); smp_z = vz(id);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pop1();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic push_pop(input int id);
        rd_pop = 1'b1;
        push(id);
        rd_pop = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode_sel = m;
        @(negedge clk);
    endtask

    task automatic edge_trig(input bit with_push, input int id);
        trig_in = 1'b1;
        if (with_push) push(id); else @(negedge clk);
        trig_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_cnt(0, "R1");
        chk_bit(thr_hit, 1'b0, "R1 thr");
        chk_bit(ovr_sticky, 1'b0, "R1 ovr");
        checks++;
        if (out_x != 0 || out_y != 0 || out_z != 0) begin
            failures++;
            $display("FAIL R1 data actual=%h_%h_%h expected=0", out_x, out_y, out_z);
        end

        // R2: pass-through shows newest, stores nothing, pops ignored
        for (int i = 0; i < 4; i++) begin
            push(i);
            chk_out(i, "R2 newest");
            chk_cnt(0, "R2 empty");
        end
        pop1();
        chk_out(3, "R2 pop ignored");

        // R3/R5/R6: stop mode fill with exhaustive threshold sweep
        set_mode(3'b001);
        for (int i = 0; i < 40; i++) begin
            int e;
            push(i);
            e = (i + 1 > 32) ? 32 : i + 1;
            chk_cnt(e, "R3 R5 fill");
            for (int t = 0; t < 32; t++) begin
                thr_level = 5'(t);
                #1;
                chk_bit(thr_hit, (t != 0) && (e >= t), "R6 threshold");
            end
        end
        chk_bit(ovr_sticky, 1'b0, "R3 no overrun");
        for (int k = 0; k < 32; k++) begin
            pop1();
            chk_out(k, "R3 order");
            chk_cnt(31 - k, "R3 drain");
        end
        push(50);
        chk_cnt(0, "R3 halted after pops");
        pop1();
        chk_out(31, "R11 empty pop data");
        chk_cnt(0, "R11 empty pop count");
        set_mode(3'b000);
        set_mode(3'b001);
        push(60);
        chk_cnt(1, "R3 resumed");

        // R4/R7: overwrite mode
        set_mode(3'b000);
        set_mode(3'b110);
        for (int i = 0; i < 40; i++) begin
            push(100 + i);
            chk_cnt((i + 1 > 32) ? 32 : i + 1, "R4 count");
            chk_bit(ovr_sticky, (i + 1 > 32), "R4 overrun");
        end
        for (int k = 0; k < 32; k++) begin
            pop1();
            chk_out(108 + k, "R4 oldest dropped");
        end
        chk_bit(ovr_sticky, 1'b1, "R7 sticky after drain");
        push(140);
        push(141);
        push_pop(142);
        chk_cnt(2, "R11 push and pop");
        chk_out(140, "R11 push and pop data");

        // R10: disabled
        fifo_en = 1'b0;
        push_pop(143);
        chk_cnt(2, "R10 count held");
        chk_out(140, "R10 data held");
        chk_bit(ovr_sticky, 1'b1, "R10 ovr held");
        set_mode(3'b000);
        chk_cnt(2, "R10 pass ignored");
        fifo_en = 1'b1;
        @(negedge clk);
        chk_cnt(0, "R7 cleared count");
        chk_bit(ovr_sticky, 1'b0, "R7 cleared by pass");

        // R8: overwrite before trigger
        set_mode(3'b011);
        for (int i = 0; i < 35; i++) push(200 + i);
        chk_cnt(32, "R8 pre-trigger count");
        chk_bit(ovr_sticky, 1'b1, "R8 pre-trigger overwrite");
        set_mode(3'b000);
        set_mode(3'b011);
        for (int i = 0; i < 3; i++) push(240 + i);
        edge_trig(1'b0, 0);
        for (int i = 3; i < 40; i++) push(240 + i);
        chk_cnt(32, "R8 stop after trigger");
        chk_bit(ovr_sticky, 1'b0, "R8 no overwrite after trigger");
        pop1();
        chk_out(240, "R8 first kept");
        push(299);
        chk_cnt(31, "R8 halted");

        // R9: pass-through until trigger, then overwrite
        set_mode(3'b000);
        set_mode(3'b100);
        for (int i = 0; i < 3; i++) begin
            push(300 + i);
            chk_cnt(0, "R9 pre-trigger empty");
        end
        chk_out(302, "R9 pre-trigger newest");
        edge_trig(1'b1, 303);
        chk_cnt(0, "R9 edge sample not stored");
        chk_out(303, "R9 edge sample shown");
        for (int i = 0; i < 35; i++) push(310 + i);
        chk_cnt(32, "R9 stored");
        chk_bit(ovr_sticky, 1'b1, "R9 overwrite");
        pop1();
        chk_out(313, "R9 oldest kept");

        // R12: mode change forgets trigger; reserved modes
        set_mode(3'b110);
        set_mode(3'b100);
        push(350);
        chk_cnt(0, "R12 trigger forgotten");
        chk_out(350, "R12 pass data");
        set_mode(3'b000);
        set_mode(3'b110);
        for (int i = 0; i < 4; i++) push(400 + i);
        set_mode(3'b010);
        push(404);
        chk_cnt(4, "R12 reserved ignores push");
        pop1();
        chk_cnt(3, "R12 reserved pop");
        chk_out(400, "R12 reserved pop data");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule